// File: doc/BRIEF.md
# Link Transmission-Error Speed Downgrade Controller

This block watches a stream of transmission-error pulses from a storage link. It counts those errors against a time window measured in time-base ticks. When the count in one window goes past a configured limit, the block lowers the link configuration by one rung of a fixed ladder.

On a serial link the ladder first lowers the PHY generation. Once the PHY is at its lowest generation, it lowers the ultra-DMA level. Below ultra-DMA level 0 it moves to PIO level 4, and then lowers the PIO level. At the PIO floor the configuration stays where it is, a complaint flag is raised, and operation carries on. A parallel link skips the PHY rung.

Every new configuration comes with a one-cycle change strobe. Host logic uses the strobe to re-issue the transfer-mode setting. The PHY limit and the starting mode are sampled while reset is held.

Top module: `link_downgrade_ctrl`

## Requirements
- R1: While rst_n is low (synchronous reset), phy_speed loads phy_limit, xfer_mode loads init_mode, and cfg_change and at_floor clear to 0.
- R2: Up to ERR_LIMIT error pulses inside one window leave phy_speed, xfer_mode and cfg_change unchanged.
- R3: The error pulse that would make the count exceed ERR_LIMIT inside a window performs exactly one ladder step. The step shows on the outputs at the same clock edge that samples that pulse.
- R4: The window opens at the first counted error. On the WIN_TICKS-th time_tick after that, the error count clears. With one tick fewer, the window is still open.
- R5: After a ladder step the error count restarts from zero, so another ERR_LIMIT+1 errors are needed for the next step.
- R6: When link_is_sata is 1 and phy_speed is above PHY_FLOOR (default 1), a step lowers phy_speed by one and leaves xfer_mode unchanged.
- R7: The xfer_mode encoding is as follows: bit 3 = 1 means ultra-DMA and bit 3 = 0 means PIO, with the level in bits 2:0. When the PHY rung is exhausted or skipped, a step in ultra-DMA level n > 0 gives level n-1.
- R8: A step taken at ultra-DMA level 0 (4'b1000) sets xfer_mode to PIO level 4 (4'b0100).
- R9: A step in PIO above level PIO_FLOOR (default 3) lowers the level by one. A step at or below PIO_FLOOR changes nothing and gives no strobe. It sets at_floor, which then holds until reset.
- R10: When link_is_sata is 0, phy_speed never changes.
- R11: cfg_change is high for exactly one cycle for each new configuration, and only when phy_speed or xfer_mode has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the starting configuration |
| err_pulse | input | 1 | One-cycle report of a transmission error |
| time_tick | input | 1 | Time-base tick that advances the window |
| link_is_sata | input | 1 | 1 for a serial link, 0 for a parallel link |
| phy_limit | input | PHY_W | Starting PHY generation, sampled in reset |
| init_mode | input | 4 | Starting transfer-mode code, sampled in reset |
| phy_speed | output | PHY_W | Current PHY generation |
| xfer_mode | output | 4 | Current transfer-mode code |
| cfg_change | output | 1 | One-cycle strobe on each new configuration |
| at_floor | output | 1 | Sticky flag set when a step finds no lower rung |

## Verification
The bench builds the block with ERR_LIMIT = 3 and WIN_TICKS = 8 instead of a real-time window of hundreds of ticks. This lets it reach both the expiring tick and the tick just before it within a few dozen cycles. A PHY limit of 2 with a start at ultra-DMA level 1 lets a single run climb down the whole ladder: PHY step, ultra-DMA steps, the move to PIO 4, PIO 3 and the floor. A second reset with link_is_sata at 0 covers the parallel path.

// File: rtl/dgr_pkg.sv
package dgr_pkg;

   // Transfer-mode code: kind bit then level
   typedef struct packed {
      logic       is_udma;
      logic [2:0] level;
   } xfer_mode_t;

   localparam logic [2:0] PIO_TOP_LEVEL = 3'd4;

   function automatic xfer_mode_t pio_entry();
      xfer_mode_t m;
      m.is_udma = 1'b0;
      m.level   = PIO_TOP_LEVEL;
      return m;
   endfunction

endpackage

// File: rtl/dgr_err_window.sv
module dgr_err_window #(
   parameter int ERR_LIMIT = 3,
   parameter int WIN_TICKS = 900
) (
   input  logic clk,
   input  logic rst_n,
   input  logic err_in,
   input  logic tick_in,
   output logic trip_o
);

   localparam int CW = $clog2(ERR_LIMIT + 1);
   localparam int TW = (WIN_TICKS > 2) ? $clog2(WIN_TICKS) : 1;
   localparam logic [CW-1:0] LIM = CW'(ERR_LIMIT);

   initial begin
      if (ERR_LIMIT < 1) $error("ERR_LIMIT must be at least 1");
      if (WIN_TICKS == 1) $error("WIN_TICKS must be 0 or at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          expire;

   assign trip_o = err_in && (cnt_q == LIM);

   generate
      if (WIN_TICKS == 0) begin : g_no_window
         assign expire = 1'b0;
      end else begin : g_window
         localparam logic [TW-1:0] LAST = TW'(WIN_TICKS - 1);
         logic [TW-1:0] tcnt_q;
         assign expire = tick_in && (cnt_q != '0) && (tcnt_q == LAST);
         always_ff @(posedge clk) begin
            if (!rst_n || trip_o || expire || (cnt_q == '0)) begin
               tcnt_q <= '0;
            end else if (tick_in) begin
               tcnt_q <= tcnt_q + 1'b1;
            end
         end
         // R4
         tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tcnt_q <= LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || trip_o) begin
         cnt_q <= '0;
      end else if (expire) begin
         cnt_q <= err_in ? CW'(1) : '0;
      end else if (err_in) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM);
   // R5
   clear_after_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip_o |=> (cnt_q == '0));

endmodule

// File: rtl/dgr_ladder.sv
module dgr_ladder
   import dgr_pkg::*;
#(
   parameter int PHY_W       = 2,
   parameter int PHY_FLOOR   = 1,
   parameter int PIO_FLOOR   = 3,
   parameter bit PHY_STEP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             is_sata_i,
   input  logic [PHY_W-1:0] phy_init_i,
   input  logic [3:0]       mode_init_i,
   output logic [PHY_W-1:0] phy_o,
   output logic [3:0]       mode_o,
   output logic             change_o,
   output logic             floor_o
);

   localparam logic [PHY_W-1:0] PHY_MIN = PHY_W'(PHY_FLOOR);
   localparam logic [2:0]       PIO_MIN = 3'(PIO_FLOOR);

   initial begin
      if (PHY_W < 1) $error("PHY_W must be at least 1");
      if (PIO_FLOOR > 4) $error("PIO_FLOOR must not exceed 4");
   end

   logic [PHY_W-1:0] phy_q, phy_n;
   xfer_mode_t       mode_q, mode_n;
   logic             change_q, floor_q;
   logic             moved, stuck, phy_can;

   generate
      if (PHY_STEP_EN) begin : g_phy_rung
         assign phy_can = is_sata_i && (phy_q > PHY_MIN);
      end else begin : g_no_phy_rung
         assign phy_can = 1'b0;
      end
   endgenerate

   always_comb begin
      phy_n  = phy_q;
      mode_n = mode_q;
      moved  = 1'b0;
      stuck  = 1'b0;
      if (step_i) begin
         if (phy_can) begin
            phy_n = phy_q - 1'b1;
            moved = 1'b1;
         end else if (mode_q.is_udma) begin
            if (mode_q.level != 3'd0) mode_n.level = mode_q.level - 3'd1;
            else                      mode_n = pio_entry();
            moved = 1'b1;
         end else if (mode_q.level > PIO_MIN) begin
            mode_n.level = mode_q.level - 3'd1;
            moved = 1'b1;
         end else begin
            stuck = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phy_q    <= phy_init_i;
         mode_q   <= mode_init_i;
         change_q <= 1'b0;
         floor_q  <= 1'b0;
      end else begin
         phy_q    <= phy_n;
         mode_q   <= mode_n;
         change_q <= moved;
         floor_q  <= floor_q | stuck;
      end
   end

   assign phy_o    = phy_q;
   assign mode_o   = mode_q;
   assign change_o = change_q;
   assign floor_o  = floor_q;

   // R11
   strobe_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      change_q |-> ((phy_q != $past(phy_q)) || (mode_q != $past(mode_q))));
   // R11
   no_silent_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!change_q && $past(rst_n)) |-> ($stable(phy_q) && $stable(mode_q)));
   // R9
   floor_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(floor_q) |-> floor_q);
   // R10
   pata_phy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_sata_i && !$past(is_sata_i) && $past(rst_n)) |-> $stable(phy_q));

endmodule

// File: rtl/link_downgrade_ctrl.sv
module link_downgrade_ctrl #(
   parameter int ERR_LIMIT = 3,
   parameter int WIN_TICKS = 900,
   parameter int PHY_W     = 2,
   parameter int PHY_FLOOR = 1,
   parameter int PIO_FLOOR = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_pulse,
   input  logic             time_tick,
   input  logic             link_is_sata,
   input  logic [PHY_W-1:0] phy_limit,
   input  logic [3:0]       init_mode,
   output logic [PHY_W-1:0] phy_speed,
   output logic [3:0]       xfer_mode,
   output logic             cfg_change,
   output logic             at_floor
);

   logic trip;

   dgr_err_window #(
      .ERR_LIMIT(ERR_LIMIT),
      .WIN_TICKS(WIN_TICKS)
   ) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .err_in (err_pulse),
      .tick_in(time_tick),
      .trip_o (trip)
   );

   dgr_ladder #(
      .PHY_W      (PHY_W),
      .PHY_FLOOR  (PHY_FLOOR),
      .PIO_FLOOR  (PIO_FLOOR),
      .PHY_STEP_EN(1'b1)
   ) u_ladder (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (trip),
      .is_sata_i  (link_is_sata),
      .phy_init_i (phy_limit),
      .mode_init_i(init_mode),
      .phy_o      (phy_speed),
      .mode_o     (xfer_mode),
      .change_o   (cfg_change),
      .floor_o    (at_floor)
   );

   // R3
   one_step_per_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trip && $past(rst_n)) |=> !cfg_change);

endmodule

// File: tb/tb_link_downgrade_ctrl.sv
module tb_link_downgrade_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int PHY_W = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             err_pulse = 1'b0;
   logic             time_tick = 1'b0;
   logic             link_is_sata = 1'b1;
   logic [PHY_W-1:0] phy_limit = 2'd2;
   logic [3:0]       init_mode = 4'b1001;
   logic [PHY_W-1:0] phy_speed;
   logic [3:0]       xfer_mode;
   logic             cfg_change;
   logic             at_floor;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   link_downgrade_ctrl #(
      .ERR_LIMIT(3),
      .WIN_TICKS(8),
      .PHY_W    (PHY_W),
      .PHY_FLOOR(1),
      .PIO_FLOOR(3)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .err_pulse   (err_pulse),
      .time_tick   (time_tick),
      .link_is_sata(link_is_sata),
      .phy_limit   (phy_limit),
      .init_mode   (init_mode),
      .phy_speed   (phy_speed),
      .xfer_mode   (xfer_mode),
      .cfg_change  (cfg_change),
      .at_floor    (at_floor)
   );

   task automatic check(string req, string what, int actual, int expected);
      n_checks++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
      end
   endtask

   task automatic check_cfg(string req, int phy, int mode, int stb);
      check(req, "phy_speed", int'(phy_speed), phy);
      check(req, "xfer_mode", int'(xfer_mode), mode);
      check(req, "cfg_change", int'(cfg_change), stb);
   endtask

   // Drive one error; returns at the negedge after the sampling edge
   task automatic pulse_err();
      @(negedge clk) err_pulse = 1'b1;
      @(negedge clk) err_pulse = 1'b0;
   endtask

   task automatic pulse_errs(int n);
      for (int i = 0; i < n; i++) pulse_err();
   endtask

   task automatic pulse_ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) time_tick = 1'b1;
         @(negedge clk) time_tick = 1'b0;
      end
   endtask

   task automatic do_reset(bit sata, logic [PHY_W-1:0] lim, logic [3:0] mode);
      @(negedge clk);
      link_is_sata = sata;
      phy_limit    = lim;
      init_mode    = mode;
      rst_n        = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic test_reset();
      do_reset(1'b1, 2'd2, 4'b1001);
      check_cfg("R1", 2, 4'b1001, 0);
      check("R1", "at_floor", int'(at_floor), 0);
   endtask

   task automatic test_threshold();
      pulse_errs(3);
      check_cfg("R2", 2, 4'b1001, 0);
      pulse_err();
      check_cfg("R3 R6", 1, 4'b1001, 1);
      @(negedge clk);
      check("R11", "cfg_change after one cycle", int'(cfg_change), 0);
   endtask

   task automatic test_clear_after_step();
      pulse_errs(3);
      check_cfg("R5", 1, 4'b1001, 0);
      pulse_err();
      check_cfg("R7", 1, 4'b1000, 1);
   endtask

   task automatic test_window_expire();
      pulse_errs(3);
      pulse_ticks(8);
      pulse_errs(3);
      check_cfg("R4 expired", 1, 4'b1000, 0);
      pulse_err();
      check_cfg("R8", 1, 4'b0100, 1);
   endtask

   task automatic test_window_open();
      pulse_errs(3);
      pulse_ticks(7);
      check_cfg("R4 open", 1, 4'b0100, 0);
      pulse_err();
      check_cfg("R4 R9 pio step", 1, 4'b0011, 1);
   endtask

   task automatic test_floor();
      pulse_errs(4);
      check_cfg("R9 floor", 1, 4'b0011, 0);
      check("R9", "at_floor", int'(at_floor), 1);
      pulse_errs(4);
      check_cfg("R9 floor again", 1, 4'b0011, 0);
      check("R9", "at_floor held", int'(at_floor), 1);
   endtask

   task automatic test_pata();
      do_reset(1'b0, 2'd2, 4'b1010);
      check("R1", "at_floor cleared", int'(at_floor), 0);
      pulse_errs(4);
      check_cfg("R10 R7", 2, 4'b1001, 1);
      pulse_errs(4);
      check_cfg("R10", 2, 4'b1000, 1);
   endtask

   initial begin
      test_reset();
      test_threshold();
      test_clear_after_step();
      test_window_expire();
      test_window_open();
      test_floor();
      test_pata();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
         $finish;
      end
   end

endmodule